// File: doc/BRIEF.md
# Chainable Converter Serial Port

This block is the serial side of one converter device that can share a chain with other copies of itself. It holds a single 22-bit shift register. The same register carries the conversion result out and the incoming command word in. A rising edge on the conversion trigger loads the parallel result from the converter model into the register. A transfer frame opens when chip select falls. Each serial clock then moves one bit out of the top of the register and one bit in from the upstream input. Because of this, the bits that leave a device are exactly the bits the next device down the chain receives.

When chip select rises, the device decodes the 22 bits left in its register as its own command. A command can write a small configuration register file, or it can request a read-back, which is shifted out in the following frame. A status output reports whether the output-count field held in configuration word 0 allows chained operation, which is only valid for a count of 0 or 1.

All pins are sampled on the system clock. The serial clock and chip select are edge-detected against their previous sampled values. Serial clock mode 0 is used: data is launched on the falling edge and captured on the rising edge.

Top module: `daisy_adc_port`

## Requirements
- R1: After reset, sdo is 0, wr_stb is 0, chain_ok is 1, and every configuration word is 0.
- R2: A rising edge on conv_start while cs_n is high loads sample_data into the shift register. A rising edge while cs_n is low has no effect on the frame's output.
- R3: A falling edge on cs_n drives register bit 21 onto sdo. Each later sclk falling edge drives the new bit 21. sdo holds its value while cs_n is high.
- R4: Each sclk rising edge while cs_n is low shifts sdi into bit 0. sclk edges while cs_n is high change nothing.
- R5: With two devices chained, a 44-clock frame returns the downstream device's word first, then the upstream device's word, each MSB first.
- R6: At a cs_n rising edge after at least 22 captures, the register decodes as follows: bits 21:20 hold the opcode (01 write, 10 read, 00 or 11 no action), bits 19:12 hold the address, and bits 11:0 hold the data. A write pulses wr_stb for one cycle with wr_addr and wr_data, and stores the data when the address is below 4.
- R7: A read reloads the register with {2'b10, address, stored word}; an address of 4 or more returns 0 in the data field. This word is shifted out in the next frame.
- R8: A frame with fewer than 22 captures is discarded: no strobe and no register change.
- R9: In a frame longer than 22 captures, only the last 22 bits received decide the command.
- R10: chain_ok is 1 exactly when bits 7:0 of configuration word 0 are at most 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| conv_start | input | 1 | Conversion trigger, active on its rising edge |
| cs_n | input | 1 | Frame select, active low |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial input from host or upstream device |
| sample_data | input | 22 | Conversion result from converter model |
| sdo | output | 1 | Serial output to next device or host |
| wr_stb | output | 1 | One-cycle pulse on a decoded write |
| wr_addr | output | 8 | Address of the decoded write |
| wr_data | output | 12 | Data of the decoded write |
| chain_ok | output | 1 | Output-count field permits chained use |

## Verification
A corrupted shift register or a misplaced shift shows up on the downstream device's sdo within the same frame, at the first bit that differs, because every bit passes through both devices in turn. A wrong capture counter appears at the next cs_n rise, as either a missing or an extra wr_stb. A damaged configuration word stays hidden until either a read-back frame returns it one frame later or chain_ok changes, so the bench follows every write with a read-back.

// File: rtl/daisy_adc_port.sv
module daisy_adc_port #(
  parameter int WORD_W  = 22,
  parameter int OP_W    = 2,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 12,
  parameter int NREGS   = 4,
  parameter int FIELD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_start,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  input  logic [WORD_W-1:0] sample_data,
  output logic              sdo,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              chain_ok
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam int IDX_W = (NREGS > 1) ? $clog2(NREGS) : 1;
  localparam logic [OP_W-1:0] OP_WR = OP_W'(1);
  localparam logic [OP_W-1:0] OP_RD = OP_W'(2);

  logic [WORD_W-1:0] usr;
  logic [CNT_W-1:0]  cap_cnt;
  logic              cs_q, sclk_q, conv_q;
  logic [DATA_W-1:0] cfg [NREGS];

  wire cs_fall   = cs_q & ~cs_n;
  wire cs_rise   = ~cs_q & cs_n;
  wire sclk_rise = ~cs_n & sclk & ~sclk_q;
  wire sclk_fall = ~cs_n & ~sclk & sclk_q;
  wire conv_rise = cs_n & conv_start & ~conv_q;

  wire [OP_W-1:0]   op   = usr[WORD_W-1 -: OP_W];
  wire [ADDR_W-1:0] addr = usr[DATA_W +: ADDR_W];
  wire [DATA_W-1:0] dat  = usr[DATA_W-1:0];
  wire full     = (cap_cnt == CNT_W'(WORD_W));
  wire in_range = (addr < ADDR_W'(NREGS));
  wire do_wr    = cs_rise & full & (op == OP_WR);
  wire do_rd    = cs_rise & full & (op == OP_RD);
  wire [DATA_W-1:0] rd_val = in_range ? cfg[addr[IDX_W-1:0]] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b0;
      conv_q <= 1'b0;
    end else begin
      cs_q   <= cs_n;
      sclk_q <= sclk;
      conv_q <= conv_start;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         usr <= '0;
    else if (conv_rise) usr <= sample_data;
    else if (sclk_rise) usr <= {usr[WORD_W-2:0], sdi};
    else if (do_rd)     usr <= {op, addr, rd_val};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cap_cnt <= '0;
    else if (cs_fall)           cap_cnt <= '0;
    else if (sclk_rise && !full) cap_cnt <= cap_cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    sdo <= 1'b0;
    else if (cs_fall || sclk_fall) sdo <= usr[WORD_W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_stb <= do_wr;
      if (do_wr) begin
        wr_addr <= addr;
        wr_data <= dat;
      end
    end
  end

  for (genvar g = 0; g < NREGS; g++) begin : g_cfg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 cfg[g] <= '0;
      else if (do_wr && addr == ADDR_W'(g)) cfg[g] <= dat;
    end
  end

  assign chain_ok = (cfg[0][FIELD_W-1:0] <= FIELD_W'(1));
endmodule

module daisy_adc_port_chk #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 12,
  parameter int FIELD_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              sdo,
  input logic              wr_stb,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              chain_ok
);
  assert_sdo_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n)) |-> $stable(sdo));

  assert_stb_after_cs_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> ($past(cs_n) && !$past(cs_n, 2)));

  assert_stb_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  assert_chain_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_addr == '0) |-> (chain_ok == (wr_data[FIELD_W-1:0] <= FIELD_W'(1))));
endmodule

bind daisy_adc_port daisy_adc_port_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FIELD_W(FIELD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdo(sdo), .wr_stb(wr_stb),
  .wr_addr(wr_addr), .wr_data(wr_data), .chain_ok(chain_ok));

// File: tb/sim_daisy_adc_port.sv
module sim_daisy_adc_port;
  logic clk = 0, rst_n = 0, conv = 0, cs_n = 1, sclk = 0, sdi = 0;
  logic [21:0] adc0 = '0, adc1 = '0;
  logic sdo0, sdo1, stb0, stb1, ok0, ok1;
  logic [7:0] a0, a1;
  logic [11:0] d0, d1;

  always #5 clk = ~clk;

  daisy_adc_port u0 (.clk(clk), .rst_n(rst_n), .conv_start(conv), .cs_n(cs_n), .sclk(sclk),
    .sdi(sdi), .sample_data(adc0), .sdo(sdo0), .wr_stb(stb0), .wr_addr(a0), .wr_data(d0), .chain_ok(ok0));
  daisy_adc_port u1 (.clk(clk), .rst_n(rst_n), .conv_start(conv), .cs_n(cs_n), .sclk(sclk),
    .sdi(sdo0), .sample_data(adc1), .sdo(sdo1), .wr_stb(stb1), .wr_addr(a1), .wr_data(d1), .chain_ok(ok1));

  int checks = 0, fails = 0;
  string tag = "R1";
  bit bit_q[$];
  logic [20:0] wr_q[$];
  bit done = 0;

  task automatic chk(input bit ok, input string t, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
    end
  endtask

  function automatic logic [21:0] mk(input logic [1:0] op, input logic [7:0] ad, input logic [11:0] dt);
    return {op, ad, dt};
  endfunction

  task automatic push_word(input logic [21:0] w);
    for (int i = 21; i >= 0; i--) bit_q.push_back(w[i]);
  endtask

  task automatic push_wr(input bit dev, input logic [7:0] ad, input logic [11:0] dt);
    wr_q.push_back({dev, ad, dt});
  endtask

  always @(posedge sclk) begin
    if (!cs_n && bit_q.size() > 0) begin
      automatic bit e = bit_q.pop_front();
      chk(sdo1 === e, tag, int'(sdo1), int'(e));
    end
  end

  always @(negedge clk) begin
    if (rst_n && stb0) begin
      if (wr_q.size() == 0) chk(0, {tag, " unexpected strobe dev0"}, 1, 0);
      else begin
        automatic logic [20:0] e = wr_q.pop_front();
        chk({1'b0, a0, d0} === e, tag, int'({1'b0, a0, d0}), int'(e));
      end
    end
    if (rst_n && stb1) begin
      if (wr_q.size() == 0) chk(0, {tag, " unexpected strobe dev1"}, 1, 0);
      else begin
        automatic logic [20:0] e = wr_q.pop_front();
        chk({1'b1, a1, d1} === e, tag, int'({1'b1, a1, d1}), int'(e));
      end
    end
  end

  task automatic frame(input logic [63:0] tx, input int n, input bit mid_conv);
    @(negedge clk) cs_n = 0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      sdi = tx[n-1-i];
      if (mid_conv && i == 3) conv = 1;
      repeat (2) @(negedge clk);
      sclk = 1;
      repeat (2) @(negedge clk);
      sclk = 0;
      conv = 0;
      repeat (2) @(negedge clk);
    end
    cs_n = 1;
    repeat (4) @(negedge clk);
    chk(bit_q.size() == 0, {tag, " bits left"}, bit_q.size(), 0);
    chk(wr_q.size() == 0, {tag, " writes left"}, wr_q.size(), 0);
    bit_q.delete();
    wr_q.delete();
  endtask

  task automatic pulse_conv;
    @(negedge clk) conv = 1;
    repeat (2) @(negedge clk);
    conv = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_sim;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_sim();
    end
  end

  initial begin
    logic [21:0] wa, wb;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    tag = "R1";
    chk(sdo0 == 0 && sdo1 == 0, "R1 sdo", int'({sdo1, sdo0}), 0);
    chk(stb0 == 0 && stb1 == 0, "R1 strobe", int'({stb1, stb0}), 0);
    chk(ok0 && ok1, "R1 chain_ok", int'({ok1, ok0}), 3);

    // R2 load, R4 sclk ignored while deselected, R5 order
    adc0 = 22'h15A5A5; adc1 = 22'h0C3F0F;
    pulse_conv();
    for (int k = 0; k < 4; k++) begin
      sclk = 1; repeat (2) @(negedge clk);
      sclk = 0; repeat (2) @(negedge clk);
    end
    chk(sdo1 == 0, "R3 sdo held while deselected", int'(sdo1), 0);
    tag = "R5 chain readout";
    push_word(adc1); push_word(adc0);
    frame(64'd0, 44, 0);

    // R6 writes
    tag = "R6 write";
    wa = mk(2'b01, 8'd1, 12'hABC); wb = mk(2'b01, 8'd2, 12'h123);
    push_word(22'd0); push_word(22'd0);
    push_wr(0, 8'd1, 12'hABC); push_wr(1, 8'd2, 12'h123);
    frame({20'd0, wb, wa}, 44, 0);

    // R7 read request, then read-back
    tag = "R4 shifted words";
    push_word(wb); push_word(wa);
    frame({20'd0, mk(2'b10, 8'd2, 12'd0), mk(2'b10, 8'd1, 12'd0)}, 44, 0);
    tag = "R7 read-back";
    push_word(mk(2'b10, 8'd2, 12'h123)); push_word(mk(2'b10, 8'd1, 12'hABC));
    frame(64'd0, 44, 0);

    // R8 short frame discarded (dev0 would decode as a write otherwise)
    adc0 = 22'h000400; adc1 = 22'h3FF000;
    pulse_conv();
    tag = "R8 short frame";
    for (int i = 21; i >= 12; i--) bit_q.push_back(adc1[i]);
    frame(64'h3FF, 10, 0);
    tag = "R8 regs unchanged";
    frame({20'd0, mk(2'b10, 8'd2, 12'd0), mk(2'b10, 8'd1, 12'd0)}, 44, 0);
    push_word(mk(2'b10, 8'd2, 12'h123)); push_word(mk(2'b10, 8'd1, 12'hABC));
    frame(64'd0, 44, 0);

    // R9 long frame, R10 flag
    tag = "R9 long frame";
    wa = mk(2'b01, 8'd0, 12'h002); wb = mk(2'b01, 8'd3, 12'hFFF);
    push_wr(0, 8'd0, 12'h002); push_wr(1, 8'd3, 12'hFFF);
    frame({14'd0, 6'b101010, wb, wa}, 50, 0);
    chk(ok0 == 0, "R10 count 2 blocks chain", int'(ok0), 0);
    chk(ok1 == 1, "R10 other device unaffected", int'(ok1), 1);
    tag = "R10 count 1";
    push_word(wb); push_word(wa);
    push_wr(0, 8'd0, 12'h001);
    frame({20'd0, 22'd0, mk(2'b01, 8'd0, 12'h001)}, 44, 0);
    chk(ok0 == 1, "R10 count 1 allows chain", int'(ok0), 1);

    // R2 trigger during frame ignored
    adc0 = 22'h2AAAAA; adc1 = 22'h155555;
    tag = "R2 trigger in frame ignored";
    push_word(22'd0); push_word(mk(2'b01, 8'd0, 12'h001));
    frame(64'd0, 44, 1);

    // R6 reserved opcode does nothing
    tag = "R6 reserved opcode";
    push_word(22'd0); push_word(22'd0);
    frame({20'd0, mk(2'b11, 8'd1, 12'h0FF), mk(2'b11, 8'd1, 12'h0FF)}, 44, 0);
    tag = "R6 reserved left regs";
    frame({20'd0, mk(2'b10, 8'd1, 12'd0), mk(2'b10, 8'd1, 12'd0)}, 44, 0);
    push_word(mk(2'b10, 8'd1, 12'h000)); push_word(mk(2'b10, 8'd1, 12'hABC));
    frame(64'd0, 44, 0);

    done = 1;
    finish_sim();
  end
endmodule